// File: doc/BRIEF.md
# Six-Layer Half-Strip Track Pattern Finder

This block takes one half-strip hit vector from each of the six layers of a strip chamber. It looks for groups of hits across the layers that line up along a plausible muon path. For every key half-strip position in the key layer, it tests a small set of track shapes. Each shape places exactly one half-strip in each layer at a fixed offset from the key. The hits that fall on the shape are counted, and the shape gets a pattern number. The number rises first with the count of hit layers and then with how straight the shape is.

Over the whole chamber, only the best candidate is kept. It is the one with the highest pattern number; when numbers are equal, the lowest key half-strip wins. The candidate is reported as valid only when its layer count reaches a minimum threshold, which is set through a port on each input vector. The block is a fixed three-register pipeline and accepts a new set of hit vectors every clock.

Top module: `pattern_finder_6l`

## Requirements
- R1: The result for a set of hit vectors captured at clock edge E appears on the outputs after edge E+2 and holds until edge E+3. A new input set is accepted every cycle.
- R2: The straight shape (shape 0) has a zero offset in every layer. At key k, it takes half-strip k from each layer.
- R3: Shape 1 uses, in layer l, half-strip k+(l-2). Shape 2 uses half-strip k-(l-2). Layer 2 is the key layer.
- R4: A shape s with c hit layers has pattern number c*3+(2-s). The highest pattern number in the chamber is reported. Because of this rule, a candidate with more hit layers always beats a straighter candidate with fewer hit layers.
- R5: Among candidates with equal pattern numbers, the one with the lowest key half-strip index is reported.
- R6: out_valid is 1 exactly when the best candidate's layer count is at least max(min_layers,1). The min_layers value is captured together with the hit vectors.
- R7: When out_valid is 0, out_key, out_pattern and out_layers are all 0.
- R8: A shape position that falls below half-strip 0 or above half-strip NUM_HS-1 counts as a miss in that layer.
- R9: While rst_n is low, all outputs are 0, whatever the inputs are.
- R10: out_layers is the number of distinct layers hit on the reported shape. Its range is 0 to 6.
- R11: Bit l*NUM_HS+h of hits_in is half-strip h of layer l, with layer 0 at the lowest bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hits_in | input | NLAYER*NUM_HS | Half-strip hits, layer-major |
| min_layers | input | $clog2(NLAYER+1) | Minimum hit layers for a valid result |
| out_valid | output | 1 | A candidate met the threshold |
| out_key | output | $clog2(NUM_HS) | Key half-strip of the best candidate |
| out_pattern | output | $clog2(NLAYER*NSHAPE+NSHAPE) | Pattern number of the best candidate |
| out_layers | output | $clog2(NLAYER+1) | Hit-layer count of the best candidate |

## Verification
The bench builds the block with NUM_HS set to 16, and keeps six layers, three shapes and key layer 2. With a narrow chamber, the leaning shapes reach past both edges at keys that the directed cases can place by hand. Random sparse vectors then cover a large share of key positions, shape ties and threshold settings. A reference model built from the shape and numbering rules scores every vector. The scoreboard then matches each expected item to the output three edges after capture.

// File: rtl/pf_pkg.sv
package pf_pkg;

   // Offset of a shape in a layer relative to the key half-strip.
   // Shape 0 is straight, shape 1 leans toward higher indices with
   // increasing layer number, and shape 2 leans the other way.
   function automatic int shape_offset(input int layer, input int shape, input int key_layer);
      int dl;
      dl = layer - key_layer;
      case (shape)
         0:       return 0;
         1:       return dl;
         default: return -dl;
      endcase
   endfunction

endpackage

// File: rtl/pf_key_scorer.sv
module pf_key_scorer
   import pf_pkg::*;
#(
   parameter int NLAYER    = 6,
   parameter int NUM_HS    = 32,
   parameter int NSHAPE    = 3,
   parameter int KEY_LAYER = 2,
   parameter int KEY       = 0,
   localparam int CNT_W    = $clog2(NLAYER + 1),
   localparam int PNUM_W   = $clog2(NLAYER * NSHAPE + NSHAPE)
) (
   input  logic [NLAYER*NUM_HS-1:0] hits,
   output logic [CNT_W-1:0]         best_cnt,
   output logic [PNUM_W-1:0]        best_pnum
);

   logic [NLAYER-1:0] lane_hit [NSHAPE];
   logic [CNT_W-1:0]  shape_cnt [NSHAPE];
   logic [PNUM_W-1:0] shape_pnum [NSHAPE];

   for (genvar s = 0; s < NSHAPE; s++) begin : g_shape
      for (genvar l = 0; l < NLAYER; l++) begin : g_layer
         localparam int IDX = KEY + shape_offset(l, s, KEY_LAYER);
         if (IDX >= 0 && IDX < NUM_HS) begin : g_in
            assign lane_hit[s][l] = hits[l*NUM_HS + IDX];
         end else begin : g_out
            assign lane_hit[s][l] = 1'b0;
         end
      end

      always_comb begin
         shape_cnt[s] = '0;
         for (int l = 0; l < NLAYER; l++) begin
            shape_cnt[s] = shape_cnt[s] + CNT_W'(lane_hit[s][l]);
         end
      end

      assign shape_pnum[s] = PNUM_W'(shape_cnt[s]) * PNUM_W'(NSHAPE)
                           + PNUM_W'(NSHAPE - 1 - s);
   end

   always_comb begin
      best_cnt  = shape_cnt[0];
      best_pnum = shape_pnum[0];
      for (int s = 1; s < NSHAPE; s++) begin
         if (shape_pnum[s] > best_pnum) begin
            best_cnt  = shape_cnt[s];
            best_pnum = shape_pnum[s];
         end
      end
   end

endmodule

// File: rtl/pf_best_select.sv
module pf_best_select #(
   parameter int NUM_HS = 32,
   parameter int CNT_W  = 3,
   parameter int PNUM_W = 5,
   localparam int KEY_W = $clog2(NUM_HS)
) (
   input  logic [NUM_HS*CNT_W-1:0]  key_cnt,
   input  logic [NUM_HS*PNUM_W-1:0] key_pnum,
   output logic [KEY_W-1:0]         sel_key,
   output logic [CNT_W-1:0]         sel_cnt,
   output logic [PNUM_W-1:0]        sel_pnum
);

   // Ascending scan with a strict compare keeps the lowest key on ties.
   always_comb begin
      sel_key  = '0;
      sel_cnt  = key_cnt[CNT_W-1:0];
      sel_pnum = key_pnum[PNUM_W-1:0];
      for (int k = 1; k < NUM_HS; k++) begin
         if (key_pnum[k*PNUM_W +: PNUM_W] > sel_pnum) begin
            sel_key  = KEY_W'(k);
            sel_cnt  = key_cnt[k*CNT_W +: CNT_W];
            sel_pnum = key_pnum[k*PNUM_W +: PNUM_W];
         end
      end
   end

endmodule

// File: rtl/pattern_finder_6l.sv
module pattern_finder_6l #(
   parameter int NLAYER    = 6,
   parameter int NUM_HS    = 32,
   parameter int NSHAPE    = 3,
   parameter int KEY_LAYER = 2,
   localparam int CNT_W    = $clog2(NLAYER + 1),
   localparam int PNUM_W   = $clog2(NLAYER * NSHAPE + NSHAPE),
   localparam int KEY_W    = $clog2(NUM_HS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NLAYER*NUM_HS-1:0] hits_in,
   input  logic [CNT_W-1:0]         min_layers,
   output logic                     out_valid,
   output logic [KEY_W-1:0]         out_key,
   output logic [PNUM_W-1:0]        out_pattern,
   output logic [CNT_W-1:0]         out_layers
);

   if (NLAYER < 3 || NLAYER > 8) begin : g_bad_layers
      $error("pattern_finder_6l: NLAYER must be 3..8");
   end
   if (NSHAPE < 1 || NSHAPE > 3) begin : g_bad_shapes
      $error("pattern_finder_6l: NSHAPE must be 1..3");
   end
   if (NUM_HS < 4) begin : g_bad_width
      $error("pattern_finder_6l: NUM_HS must be at least 4");
   end
   if (KEY_LAYER < 0 || KEY_LAYER >= NLAYER) begin : g_bad_key
      $error("pattern_finder_6l: KEY_LAYER out of range");
   end

   // Stage 1: capture inputs
   logic [NLAYER*NUM_HS-1:0] hits_q;
   logic [CNT_W-1:0]         min_q1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hits_q <= '0;
         min_q1 <= '0;
      end else begin
         hits_q <= hits_in;
         min_q1 <= min_layers;
      end
   end

   // Stage 2: per-key scoring
   logic [NUM_HS*CNT_W-1:0]  key_cnt_c,  key_cnt_q;
   logic [NUM_HS*PNUM_W-1:0] key_pnum_c, key_pnum_q;
   logic [CNT_W-1:0]         min_q2;

   for (genvar k = 0; k < NUM_HS; k++) begin : g_key
      pf_key_scorer #(
         .NLAYER    (NLAYER),
         .NUM_HS    (NUM_HS),
         .NSHAPE    (NSHAPE),
         .KEY_LAYER (KEY_LAYER),
         .KEY       (k)
      ) i_scorer (
         .hits      (hits_q),
         .best_cnt  (key_cnt_c[k*CNT_W +: CNT_W]),
         .best_pnum (key_pnum_c[k*PNUM_W +: PNUM_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_cnt_q  <= '0;
         key_pnum_q <= '0;
         min_q2     <= '0;
      end else begin
         key_cnt_q  <= key_cnt_c;
         key_pnum_q <= key_pnum_c;
         min_q2     <= min_q1;
      end
   end

   // Stage 3: chamber-wide selection and threshold
   logic [KEY_W-1:0]  sel_key;
   logic [CNT_W-1:0]  sel_cnt;
   logic [PNUM_W-1:0] sel_pnum;
   logic [CNT_W-1:0]  thr;
   logic              pass;
   logic [CNT_W-1:0]  min_q3;

   pf_best_select #(
      .NUM_HS (NUM_HS),
      .CNT_W  (CNT_W),
      .PNUM_W (PNUM_W)
   ) i_select (
      .key_cnt  (key_cnt_q),
      .key_pnum (key_pnum_q),
      .sel_key  (sel_key),
      .sel_cnt  (sel_cnt),
      .sel_pnum (sel_pnum)
   );

   assign thr  = (min_q2 == '0) ? CNT_W'(1) : min_q2;
   assign pass = (sel_cnt >= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_key     <= '0;
         out_pattern <= '0;
         out_layers  <= '0;
         min_q3      <= '0;
      end else begin
         out_valid   <= pass;
         out_key     <= pass ? sel_key  : '0;
         out_pattern <= pass ? sel_pnum : '0;
         out_layers  <= pass ? sel_cnt  : '0;
         min_q3      <= min_q2;
      end
   end

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_key == '0 && out_pattern == '0 && out_layers == '0));

   // R4
   pnum_layers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_pattern) >= int'(out_layers) * NSHAPE &&
                     int'(out_pattern) <  (int'(out_layers) + 1) * NSHAPE));

   // R10
   layer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(out_layers) <= NLAYER);

   // R6
   valid_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_layers != '0);

   // R6
   valid_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_layers >= min_q3);

endmodule

// File: tb/test_pattern_finder_6l.sv
module test_pattern_finder_6l;

   localparam int NL     = 6;
   localparam int NH     = 16;
   localparam int NS     = 3;
   localparam int CNT_W  = $clog2(NL + 1);
   localparam int PNUM_W = $clog2(NL * NS + NS);
   localparam int KEY_W  = $clog2(NH);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NL*NH-1:0]     hits_in = '0;
   logic [CNT_W-1:0]     min_layers = CNT_W'(4);
   logic                 out_valid;
   logic [KEY_W-1:0]     out_key;
   logic [PNUM_W-1:0]    out_pattern;
   logic [CNT_W-1:0]     out_layers;

   always #2.5 clk = ~clk;

   pattern_finder_6l #(.NLAYER(NL), .NUM_HS(NH), .NSHAPE(NS), .KEY_LAYER(2)) i_pattern_finder_6l (
      .clk(clk), .rst_n(rst_n), .hits_in(hits_in), .min_layers(min_layers),
      .out_valid(out_valid), .out_key(out_key), .out_pattern(out_pattern), .out_layers(out_layers)
   );

   typedef struct {
      int    cyc;
      int    v;
      int    k;
      int    p;
      int    c;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Reference scoring from the shape and numbering rules
   function automatic int offs(input int l, input int s);
      if (s == 0) return 0;
      if (s == 1) return l - 2;
      return 2 - l;
   endfunction

   function automatic void model(input logic [NL*NH-1:0] h, input int mn,
                                 output int v, output int k, output int p, output int c);
      int bp, bk, bc, cnt, idx, thr;
      bp = -1; bk = 0; bc = 0;
      for (int key = 0; key < NH; key++) begin
         for (int s = 0; s < NS; s++) begin
            cnt = 0;
            for (int l = 0; l < NL; l++) begin
               idx = key + offs(l, s);
               if (idx >= 0 && idx < NH && h[l*NH + idx]) cnt++;
            end
            if (cnt * NS + (NS - 1 - s) > bp) begin
               bp = cnt * NS + (NS - 1 - s);
               bk = key;
               bc = cnt;
            end
         end
      end
      thr = (mn == 0) ? 1 : mn;
      if (bc >= thr) begin
         v = 1; k = bk; p = bp; c = bc;
      end else begin
         v = 0; k = 0; p = 0; c = 0;
      end
   endfunction

   function automatic logic [NL*NH-1:0] put(input logic [NL*NH-1:0] h, input int l, input int idx);
      logic [NL*NH-1:0] r;
      r = h;
      if (idx >= 0 && idx < NH) r[l*NH + idx] = 1'b1;
      return r;
   endfunction

   function automatic logic [NL*NH-1:0] track(input int key, input int s, input int nlay);
      logic [NL*NH-1:0] r;
      r = '0;
      for (int l = 0; l < nlay; l++) r = put(r, l, key + offs(l, s));
      return r;
   endfunction

   task automatic send(input logic [NL*NH-1:0] h, input int mn, input string tag);
      exp_t e;
      @(negedge clk);
      hits_in    = h;
      min_layers = CNT_W'(mn);
      model(h, mn, e.v, e.k, e.p, e.c);
      e.cyc = cyc;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic expect_item(input string tag, input int v, input int k, input int p, input int c,
                              input int ev, input int ek, input int ep, input int ec);
      n_chk++;
      if (v != ev || k != ek || p != ep || c != ec) begin
         n_fail++;
         $display("FAIL %s: got v=%0d key=%0d pat=%0d lay=%0d, expected v=%0d key=%0d pat=%0d lay=%0d",
                  tag, v, k, p, c, ev, ek, ep, ec);
      end
   endtask

   // Monitor: compares each expected item three edges after capture (R1)
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0 && q[0].cyc + 3 <= cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.cyc + 3 != cyc) begin
               n_chk++;
               n_fail++;
               $display("FAIL R1 %s: item compared late at cycle %0d, expected cycle %0d",
                        e.tag, cyc, e.cyc + 3);
            end else begin
               expect_item(e.tag, int'(out_valid), int'(out_key), int'(out_pattern), int'(out_layers),
                           e.v, e.k, e.p, e.c);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 50000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      finish_run();
   end

   initial begin
      logic [NL*NH-1:0] h;
      // R9: outputs stay zero in reset even with busy inputs
      hits_in = '1;
      min_layers = CNT_W'(1);
      repeat (4) @(negedge clk);
      expect_item("R9 reset", int'(out_valid), int'(out_key), int'(out_pattern), int'(out_layers),
                  0, 0, 0, 0);
      @(negedge clk);
      expect_item("R9 reset hold", int'(out_valid), int'(out_key), int'(out_pattern), int'(out_layers),
                  0, 0, 0, 0);
      rst_n = 1'b1;
      hits_in = '0;

      send('0, 4, "R6 R7 empty");
      send('0, 0, "R6 min zero empty");
      // R2 R11: straight full track, pattern 6*3+2=20
      send(track(5, 0, 6), 4, "R1 R2 R11 straight key5");
      // R3: lean shape 1 at key 7, pattern 19
      send(track(7, 1, 6), 4, "R3 shape1 key7");
      // R3: lean shape 2 at key 9, pattern 18
      send(track(9, 2, 6), 4, "R3 shape2 key9");
      // R5: equal straight tracks, lowest key wins
      send(track(3, 0, 6) | track(12, 0, 6), 4, "R5 tie key3");
      // R6: three layers under and at threshold
      send(track(6, 0, 3), 4, "R6 below min");
      send(track(6, 0, 3), 3, "R6 at min");
      send(track(6, 0, 6), 6, "R6 min six");
      // R4: five-layer lean beats four-layer straight
      send(track(2, 0, 4) | track(10, 1, 5), 4, "R4 layers over straightness");
      // R4: equal count, straight beats lean
      send(track(2, 1, 5) | track(11, 0, 5), 4, "R4 straight over lean");
      // R8: lean shapes at both chamber edges
      send(track(0, 1, 6), 4, "R8 low edge shape1");
      send(track(NH - 1, 1, 6), 3, "R8 high edge shape1");
      send(track(0, 2, 6), 3, "R8 low edge shape2");
      // R10: every layer full, count capped at six
      send('1, 4, "R10 all hits");
      // R1: back-to-back distinct vectors every cycle
      for (int i = 0; i < 400; i++) begin
         h = '0;
         for (int w = 0; w < NL*NH; w += 32) begin
            logic [31:0] a;
            a = $urandom() & $urandom();
            for (int b = 0; b < 32 && w + b < NL*NH; b++) h[w + b] = a[b];
         end
         if (i % 3 == 0) h = h | track(int'($urandom_range(0, NH - 1)), int'($urandom_range(0, NS - 1)), 6);
         send(h, int'($urandom_range(0, 6)), "R1 R4 R5 R6 R8 random");
      end
      send('0, 4, "R7 drain");
      repeat (8) @(negedge clk);
      if (q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1: got %0d unmatched items, expected 0", q.size());
      end
      finish_run();
   end

endmodule